// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers seven active-low interrupt request lines from peripherals and reports the most urgent one to the processor as a 3-bit active-low priority level. Level 7 is the most urgent and cannot be masked; an all-high level code means that nothing is requesting.

When the processor acknowledges an interrupt, it runs a bus cycle with function code 111 and the address strobe asserted. In that cycle the serviced level sits on address bits 3..1 and every higher address bit is one. The controller answers such a cycle with the vector number configured for that level on an 8-bit data output, raises the output's drive enable and asserts a data-transfer acknowledge. A configured vector below 64 would point into the range kept for other exceptions. The controller therefore substitutes a vector from the user-interrupt range. If the acknowledged level has no pending source, the controller stays silent and leaves the cycle to an external bus-timeout circuit.

Top module: `irq_vector_ctrl`

## Requirements
- R1: One clock after the request lines change, `ipl_n` carries the bitwise inverse of the highest level L (1..7) whose line `irq_n[L-1]` is low. Lower levels that are also requesting have no effect.
- R2: When no request line is low, `ipl_n` reads 3'b111 one clock later.
- R3: A low `irq_n[6]` (level 7) yields `ipl_n` = 3'b000 one clock later. This holds whatever the other lines are and whether or not an acknowledge cycle is running.
- R4: An acknowledge cycle matches when `as_n` is 0, `fc` is 3'b111, `addr[23:4]` are all ones, the level in `addr[3:1]` is nonzero and that level's request line is low. One clock after a match, `dtack_n` is 0, `d_oe` is 1 and `d_out` holds the vector. All three follow the match status every clock.
- R5: The vector for level L is `vec_cfg[8L-1:8L-8]`. A configured value below 64 is replaced by 64+L.
- R6: If the level on `addr[3:1]` is 0, or that level's request line is high, one clock later `dtack_n` is 1, `d_oe` is 0 and `d_out` is 0.
- R7: One clock after a cycle with `as_n` high, with `fc` other than 3'b111, or with any of `addr[23:4]` low, `dtack_n` is 1, `d_oe` is 0 and `d_out` is 0.
- R8: Acknowledging a level does not clear it. `ipl_n` keeps reporting the level until its source raises the request line.
- R9: While `rst_n` is low, `ipl_n` is 3'b111, `dtack_n` is 1, `d_oe` is 0 and `d_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 7 | Active-low request lines; bit L-1 is level L |
| vec_cfg | input | 56 | Vector numbers; byte L-1 belongs to level L |
| as_n | input | 1 | Active-low address strobe |
| fc | input | 3 | Bus-cycle function code |
| addr | input | 23 | Word address bits 23..1 |
| ipl_n | output | 3 | Active-low encoded priority level |
| dtack_n | output | 1 | Active-low data-transfer acknowledge |
| d_out | output | 8 | Vector number for the low data byte |
| d_oe | output | 1 | Drive enable for `d_out` |

## Verification
Every output is registered, so every result is due exactly one clock edge after the inputs that caused it. The bench changes inputs on the falling edge. On each rising edge its behavioural model computes the expected values from the inputs present at that edge. It compares the design's outputs with these values on the next falling edge, which puts every comparison one register stage after its stimulus and clear of the active edge.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int ADDR_W = 23,
  parameter int LVL_W  = 3,
  parameter int VEC_W  = 8,
  localparam int LEVELS = (1 << LVL_W) - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LEVELS-1:0]       irq_n,
  input  logic [LEVELS*VEC_W-1:0] vec_cfg,
  input  logic                    as_n,
  input  logic [2:0]              fc,
  input  logic [ADDR_W:1]         addr,
  output logic [LVL_W-1:0]        ipl_n,
  output logic                    dtack_n,
  output logic [VEC_W-1:0]        d_out,
  output logic                    d_oe
);
  localparam int USER_BASE = 1 << (VEC_W - 2);

  logic [LEVELS:0]            pend;
  logic [LVL_W-1:0]           top;
  logic [LVL_W-1:0]           ack_lvl;
  logic [(LEVELS+1)*VEC_W-1:0] cfg_ext;
  logic [VEC_W-1:0]           cfg_v;
  logic [VEC_W-1:0]           vec;
  logic                       match;

  assign pend    = {~irq_n, 1'b0};
  assign ack_lvl = addr[LVL_W:1];
  assign cfg_ext = {vec_cfg, {VEC_W{1'b0}}};
  assign cfg_v   = cfg_ext[int'(ack_lvl)*VEC_W +: VEC_W];
  assign vec     = (int'(cfg_v) < USER_BASE) ? VEC_W'(USER_BASE + int'(ack_lvl)) : cfg_v;
  assign match   = !as_n && (fc == 3'b111) && (&addr[ADDR_W:LVL_W+1]) && pend[ack_lvl];

  always_comb begin
    top = '0;
    for (int i = 1; i <= LEVELS; i++)
      if (pend[i]) top = LVL_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipl_n   <= '1;
      dtack_n <= 1'b1;
      d_oe    <= 1'b0;
      d_out   <= '0;
    end else begin
      ipl_n   <= ~top;
      dtack_n <= !match;
      d_oe    <= match;
      d_out   <= match ? vec : '0;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int ADDR_W = 23,
  parameter int LVL_W  = 3,
  parameter int VEC_W  = 8,
  localparam int LEVELS = (1 << LVL_W) - 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LEVELS-1:0]       irq_n,
  input logic                    as_n,
  input logic [2:0]              fc,
  input logic [LVL_W-1:0]        ipl_n,
  input logic                    dtack_n,
  input logic [VEC_W-1:0]        d_out,
  input logic                    d_oe
);
  a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (&irq_n) |=> (ipl_n == '1));
  a_r3_top_level: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n[LEVELS-1] |=> (ipl_n == '0));
  a_r5_user_range: assert property (@(posedge clk) disable iff (!rst_n)
    d_oe |-> (int'(d_out) >= (1 << (VEC_W - 2))));
  a_r4_dtack_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (d_oe != dtack_n));
  a_r7_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |=> (dtack_n && !d_oe));
  a_r7_other_fc: assert property (@(posedge clk) disable iff (!rst_n)
    (fc != 3'b111) |=> (dtack_n && !d_oe));
  a_r7_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !d_oe |-> (d_out == '0));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .ADDR_W(ADDR_W), .LVL_W(LVL_W), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .as_n(as_n), .fc(fc),
  .ipl_n(ipl_n), .dtack_n(dtack_n), .d_out(d_out), .d_oe(d_oe)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  irq_n = 7'h7f;
  logic [55:0] vec_cfg = '0;
  logic        as_n = 1'b1;
  logic [2:0]  fc = 3'b000;
  logic [23:1] addr = '0;
  logic [2:0]  ipl_n;
  logic        dtack_n;
  logic [7:0]  d_out;
  logic        d_oe;

  int checks = 0;
  int errors = 0;
  string req = "R9";
  logic [2:0] e_ipl;
  logic       e_dtack, e_oe;
  logic [7:0] e_dout;

  always #4 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .vec_cfg(vec_cfg),
    .as_n(as_n), .fc(fc), .addr(addr), .ipl_n(ipl_n),
    .dtack_n(dtack_n), .d_out(d_out), .d_oe(d_oe)
  );

  always @(posedge clk) begin
    int hi;
    int lvl;
    int v;
    bit ok;
    hi = 0;
    for (int i = 1; i <= 7; i++) if (irq_n[i-1] == 1'b0) hi = i;
    lvl = int'(addr[3:1]);
    ok = !as_n && fc == 3'b111 && addr[23:4] == 20'hfffff && lvl != 0 && irq_n[lvl-1] == 1'b0;
    v = 0;
    if (ok) begin
      v = int'(vec_cfg[lvl*8-1 -: 8]);
      if (v < 64) v = 64 + lvl;
    end
    if (!rst_n) begin
      e_ipl = 3'b111; e_dtack = 1'b1; e_oe = 1'b0; e_dout = 8'h00;
    end else begin
      e_ipl = ~3'(hi); e_dtack = !ok; e_oe = ok; e_dout = 8'(v);
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmp("ipl_n", int'(ipl_n), int'(e_ipl));
      cmp("dtack_n", int'(dtack_n), int'(e_dtack));
      cmp("d_oe", int'(d_oe), int'(e_oe));
      cmp("d_out", int'(d_out), int'(e_dout));
    end
  endtask

  task automatic ack(int lvl);
    as_n = 1'b0; fc = 3'b111; addr = {20'hfffff, 3'(lvl)};
  endtask

  task automatic idle_bus();
    as_n = 1'b1; fc = 3'b001; addr = 23'h000123;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    req = "R9";
    vec_cfg = {8'h97, 8'h86, 8'h10, 8'h75, 8'hc4, 8'h00, 8'hf2};
    ack(2); irq_n = 7'h00;
    tick(3);
    @(negedge clk); rst_n = 1'b1; idle_bus(); irq_n = 7'h7f;
    req = "R2"; tick(2);
    req = "R1";
    for (int l = 1; l <= 6; l++) begin irq_n = ~(7'(1) << (l-1)); tick(); end
    irq_n = 7'b1110101; tick();
    irq_n = 7'b1011110; tick();
    req = "R3";
    irq_n = 7'b0111111; tick();
    irq_n = 7'b0000000; tick();
    req = "R2"; irq_n = 7'h7f; tick();
    req = "R4";
    irq_n = 7'b1111011; ack(3); tick(3);
    irq_n = 7'b1111110; ack(1); tick(2);
    req = "R5";
    irq_n = 7'b1111101; ack(2); tick(2);
    irq_n = 7'b1011111; ack(6); tick(2);
    irq_n = 7'b0111111; ack(7); tick(2);
    req = "R6";
    irq_n = 7'b1110111; ack(5); tick(2);
    ack(0); tick(2);
    req = "R7";
    irq_n = 7'b1101111; ack(5); as_n = 1'b1; tick(2);
    ack(5); fc = 3'b101; tick(2);
    ack(5); addr[12] = 1'b0; tick(2);
    req = "R3";
    irq_n = 7'b1111011; ack(3); tick(); irq_n = 7'b0111011; tick(2);
    req = "R8";
    irq_n = 7'b1111011; ack(3); tick(2); idle_bus(); tick(3);
    irq_n = 7'h7f; tick(2);
    req = "R4";
    for (int k = 0; k < 400; k++) begin
      irq_n = 7'($urandom);
      if ($urandom_range(0, 2) == 0) vec_cfg = {$urandom, $urandom};
      if ($urandom_range(0, 1) == 0) ack($urandom_range(0, 7));
      else begin
        as_n = 1'($urandom); fc = 3'($urandom); addr = 23'($urandom);
        if ($urandom_range(0, 1) == 0) addr[23:4] = 20'hfffff;
      end
      tick();
    end
    req = "R9"; rst_n = 1'b0; tick(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule